// File: doc/BRIEF.md
# Stereo Pair Channel Processor

This block takes one stereo pair of signed PCM samples, left and right, with a valid strobe. It applies one channel operation to the pair and sends the result on with a fixed latency of one clock. It sits after a crosspoint output and before an embedder or a converter. A chip places one instance per output pair, and each instance has its own mode select.

The operations are:
- pass-through
- left/right exchange
- copying either channel onto both outputs
- polarity inversion of one or both channels
- a mono mode that puts the mean of the two channels on both outputs
- conversion of AB (left/right) stereo to MS (mid/side) stereo

Sums and differences use one extra bit and an arithmetic right shift, so they never overflow. Inverting the most negative sample saturates to the most positive one.

The mode is sampled only together with a valid sample. A mode change therefore always takes effect on a sample boundary, and the output never mixes two modes within one pair.

Top module: `stereo_pair_matrix`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0 and both output samples are 0.
- R2: A sample accepted with in_valid=1 at a rising edge appears on out_left/out_right with out_valid=1 right after that edge. After an edge with in_valid=0, out_valid is 0 and both outputs keep their previous values.
- R3: Mode 0 and every unused mode code (10 to 15) pass the pair through: out_left=L and out_right=R.
- R4: Mode 1 exchanges the channels: out_left=R and out_right=L.
- R5: Mode 2 puts L on both outputs. Mode 3 puts R on both outputs.
- R6: Mode 4 inverts the left channel (out_left=-L, out_right=R). Mode 5 inverts the right channel. Mode 8 inverts both. Inverting -2^23 gives 2^23-1.
- R7: Mode 6 sets both outputs to floor((L+R)/2), computed without overflow for every input pair.
- R8: Mode 7 converts AB to MS: out_left=floor((L+R)/2) (mid) and out_right=floor((L-R)/2) (side), computed without overflow.
- R9: Mode 9 exchanges the channels and inverts both: out_left=-R and out_right=-L, with the same saturation rule as R6.
- R10: The mode input matters only in a cycle with in_valid=1. Changing it while in_valid=0 changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair is valid this cycle |
| in_left | input | 24 | Left (A) sample, two's complement |
| in_right | input | 24 | Right (B) sample, two's complement |
| mode | input | 4 | Channel operation select, sampled with in_valid |
| out_valid | output | 1 | Output pair is valid this cycle |
| out_left | output | 24 | Processed left or mid sample |
| out_right | output | 24 | Processed right or side sample |

## Verification
The embedded properties assume only that the inputs hold stable, known values at each rising edge. They place no limit on how valid strobes space out: back-to-back, sparse and gapped sample streams are all legal. The stimulus changes inputs only on falling edges. It covers full-scale extremes, including the most negative code, in every mode, so that the saturation and extra-bit paths are taken. During idle gaps it scrambles the mode and the samples, which exercises the assumption that only strobed cycles count.

// File: rtl/stereo_pair_matrix.sv
module stereo_pair_matrix #(
  parameter int W  = 24,
  parameter int MW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic [MW-1:0] mode,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] neg_sat(input logic [W-1:0] x);
    return (x == MINV) ? MAXV : W'(-x);
  endfunction

  function automatic logic [W-1:0] half(input logic signed [W:0] v);
    return W'(v >>> 1);
  endfunction

  logic signed [W:0] sum_w, dif_w;
  assign sum_w = $signed({in_left[W-1], in_left}) + $signed({in_right[W-1], in_right});
  assign dif_w = $signed({in_left[W-1], in_left}) - $signed({in_right[W-1], in_right});

  logic [W-1:0] nl, nr;
  always_comb begin
    nl = in_left;
    nr = in_right;
    case (mode)
      MW'(1): begin nl = in_right;          nr = in_left;           end
      MW'(2): begin nl = in_left;           nr = in_left;           end
      MW'(3): begin nl = in_right;          nr = in_right;          end
      MW'(4): begin nl = neg_sat(in_left);  nr = in_right;          end
      MW'(5): begin nl = in_left;           nr = neg_sat(in_right); end
      MW'(6): begin nl = half(sum_w);       nr = half(sum_w);       end
      MW'(7): begin nl = half(sum_w);       nr = half(dif_w);       end
      MW'(8): begin nl = neg_sat(in_left);  nr = neg_sat(in_right); end
      MW'(9): begin nl = neg_sat(in_right); nr = neg_sat(in_left);  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= nl;
        out_right <= nr;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));
  // R4
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MW'(1)) |=> (out_left == $past(in_right) && out_right == $past(in_left)));
  // R3
  unused_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode >= MW'(10)) |=> (out_left == $past(in_left) && out_right == $past(in_right)));
  // R7
  mono_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MW'(6)) |=> (out_left == out_right));
  // R6
  inv_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MW'(4) && in_left == MINV) |=> (out_left == MAXV));

endmodule

// File: tb/stereo_pair_matrix_test.sv
module stereo_pair_matrix_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [3:0] mode = '0;
  logic out_valid;
  logic [23:0] out_left, out_right;

  always #2.5 clk = ~clk;

  stereo_pair_matrix uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .mode(mode), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [47:0] expq[$];
  logic [3:0] modeq[$];
  logic [47:0] last_out = '0;

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5, 4'd8: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd9: return "R9";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [23:0] inv(input logic [23:0] x);
    longint v;
    v = -longint'($signed(x));
    if (v > 8388607) v = 8388607;
    return v[23:0];
  endfunction

  function automatic logic [47:0] model(input logic [23:0] l, input logic [23:0] r, input logic [3:0] m);
    longint a, b, mid, side;
    a = longint'($signed(l));
    b = longint'($signed(r));
    mid = (a + b) >>> 1;
    side = (a - b) >>> 1;
    case (m)
      4'd1: return {r, l};
      4'd2: return {l, l};
      4'd3: return {r, r};
      4'd4: return {inv(l), r};
      4'd5: return {l, inv(r)};
      4'd6: return {mid[23:0], mid[23:0]};
      4'd7: return {mid[23:0], side[23:0]};
      4'd8: return {inv(l), inv(r)};
      4'd9: return {inv(r), inv(l)};
      default: return {l, r};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] l, input logic [23:0] r, input logic [3:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r; mode = m;
    expq.push_back(model(l, r, m));
    modeq.push_back(m);
  endtask

  // R2 R10: idle cycles with scrambled inputs must leave outputs untouched
  task automatic idle_scramble(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_left = 24'h5A5A5A ^ 24'(i); in_right = 24'hA5A5A5; mode = 4'(i + 1);
    end
    @(negedge clk);
    check(!out_valid && {out_left, out_right} == last_out, "R10",
          {out_left, out_right}, last_out);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2", {out_left, out_right}, '0);
      end else begin
        logic [47:0] e;
        logic [3:0] m;
        e = expq.pop_front();
        m = modeq.pop_front();
        check({out_left, out_right} == e, req_of(m), {out_left, out_right}, e);
        last_out = {out_left, out_right};
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && out_left == 0 && out_right == 0, "R1", {out_left, out_right}, '0);
    @(negedge clk); rst_n = 1'b1;
    check(!out_valid && out_left == 0 && out_right == 0, "R1", {out_left, out_right}, '0);

    // every mode over corner pairs, back to back
    for (int m = 0; m < 16; m++) begin
      send(24'h000001, 24'h000003, 4'(m));
      send(24'h800000, 24'h800000, 4'(m));
      send(24'h7FFFFF, 24'h7FFFFF, 4'(m));
      send(24'h800000, 24'h7FFFFF, 4'(m));
      send(24'h7FFFFF, 24'h800000, 4'(m));
      send(24'hFFFFFF, 24'h000000, 4'(m));
      send(24'h123456, 24'hFEDCBA, 4'(m));
    end
    @(negedge clk); in_valid = 1'b0;
    idle_scramble(4);

    // sparse stream with mode changes between samples (R2, R10)
    for (int k = 0; k < 40; k++) begin
      send(24'(k * 24'h01F3A7), 24'(24'hC00000 + k * 24'h00B1D3), 4'(k % 10));
      @(negedge clk); in_valid = 1'b0; mode = 4'(k + 3);
      if (k % 8 == 7) idle_scramble(2);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R2: every sent sample came out
    check(expq.size() == 0, "R2", 48'(expq.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule